// File: doc/BRIEF.md
# PHY Address Discovery Scanner

This block locates an attached Ethernet PHY on a management bus. It does not drive the management bus itself. It drives an MDIO engine through a request, busy and read-data handshake. At each candidate address it asks the engine for a read of the basic status register, which is register 1. It then checks the returned word against a capability filter.

When a preferred address is enabled, the scanner tries that address first. If the preferred address answers correctly, the search ends there. Otherwise, or when no preferred address is enabled, the scanner walks the address space from the highest address down to zero. It stops at the first address that passes the filter.

When the sequence ends, the block gives a one-cycle completion pulse. It also gives a found flag and the winning address, and both hold until the next start. A start request at any time abandons the current sequence and begins again from the first step.

Top module: `phy_probe`

## Requirements
- R1: After reset, `found`, `done` and `mdioReq` are 0 and `foundAddr` is 0.
- R2: Every read request carries register number 1 on `mdioReg`.
- R3: A read response is accepted only when it is not 16'hFFFF and bits 12, 11 and 3 (mask 16'h1808) are all set. All other words are rejected.
- R4: With `prefEn` high at start, the first read goes to `prefAddr`. If that read is accepted, the sequence ends after exactly one read, with `found`=1 and `foundAddr`=`prefAddr`.
- R5: With `prefEn` low at start, `prefAddr` has no effect and the first read goes to address 31.
- R6: The fallback scan reads addresses in strictly descending order from 31. It ends at the first accepted address, and that address is reported in `foundAddr` with `found`=1. A failed preferred read is followed by a scan that starts at 31.
- R7: If no address is accepted, the sequence ends with `found`=0 after 32 scan reads, or 33 reads when a preferred read came first.
- R8: A request is raised only while `mdioBusy` is low. It is held until the engine raises `mdioBusy`. The response is taken from `mdioData` once `mdioBusy` falls again.
- R9: `done` is high for exactly one cycle per finished sequence. `found` and `foundAddr` then stay stable until the next start.
- R10: A start pulse during a running sequence abandons it and restarts from the first step, using the new `prefEn` and `prefAddr`.
- R11: `mdioAddr` is stable for as long as `mdioReq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins or restarts discovery |
| prefEn | input | 1 | A preferred address is supplied |
| prefAddr | input | 5 | Preferred address to try first |
| mdioReq | output | 1 | Read request to the MDIO engine |
| mdioAddr | output | 5 | PHY address of the request |
| mdioReg | output | 5 | Register number of the request (always 1) |
| mdioBusy | input | 1 | Engine has accepted a request and is working |
| mdioData | input | 16 | Read data, valid once busy falls |
| found | output | 1 | A valid PHY was found in the last sequence |
| foundAddr | output | 5 | Address of the PHY that was found |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs the scanner against a behavioural MDIO engine. The engine has random acceptance latency and random busy length, and it serves a per-address response table. Every accepted request address is logged, so the whole visiting order is compared, not only the final result.

Several kinds of table are used, and each one tells apart a different failure:
- Tables where all entries are 16'hFFFF separate the all-ones rejection from the mask test, because 16'hFFFF contains the mask.
- Tables where one entry misses a single mask bit catch a partial mask compare.
- Tables where only address 0 or only address 31 is valid expose off-by-one and wrap errors at both ends of the scan.
- Preferred-valid, preferred-invalid and preferred-disabled runs separate the preferred path from the scan and show that `prefAddr` is ignored when disabled.
- A restart in mid-sequence shows that stale state is dropped.

// File: rtl/phy_probe_pkg.sv
package phy_probe_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clearRes;   // drop previous result
    logic loadPref;   // candidate <= preferred address
    logic loadTop;    // candidate <= highest address
    logic decAddr;    // candidate <= candidate - 1
    logic capture;    // latch engine read data
    logic setFound;   // record candidate as result
    logic finish;     // raise completion pulse
  } probeStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_ISSUE,
    ST_WAIT,
    ST_EVAL
  } probeState_t;

endpackage

// File: rtl/phy_probe_ctrl.sv
module phy_probe_ctrl
  import phy_probe_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          prefEn,
  input  logic          mdioBusy,
  input  logic          respOk,
  input  logic          addrZero,
  output logic          mdioReq,
  output probeStrobes_t strb
);

  probeState_t state, stateNxt;
  logic        prefPhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      prefPhase <= 1'b0;
    end else begin
      state <= stateNxt;
      if (start)
        prefPhase <= prefEn;
      else if (state == ST_EVAL && !respOk)
        prefPhase <= 1'b0;
    end
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    mdioReq  = 1'b0;
    if (start) begin
      strb.clearRes = 1'b1;
      if (prefEn) strb.loadPref = 1'b1;
      else        strb.loadTop  = 1'b1;
      stateNxt = ST_SETTLE;
    end else begin
      unique case (state)
        ST_IDLE: ;
        // wait for the engine to be idle before a new request
        ST_SETTLE: if (!mdioBusy) stateNxt = ST_ISSUE;
        ST_ISSUE: begin
          mdioReq = 1'b1;
          if (mdioBusy) stateNxt = ST_WAIT;
        end
        ST_WAIT: if (!mdioBusy) begin
          strb.capture = 1'b1;
          stateNxt     = ST_EVAL;
        end
        ST_EVAL: begin
          if (respOk) begin
            strb.setFound = 1'b1;
            strb.finish   = 1'b1;
            stateNxt      = ST_IDLE;
          end else if (prefPhase) begin
            strb.loadTop = 1'b1;
            stateNxt     = ST_SETTLE;
          end else if (addrZero) begin
            strb.finish = 1'b1;
            stateNxt    = ST_IDLE;
          end else begin
            strb.decAddr = 1'b1;
            stateNxt     = ST_SETTLE;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  // R8: a raised request stays up until the engine takes it
  assert_hold_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mdioReq && !mdioBusy && !start) |=> mdioReq);

endmodule

// File: rtl/phy_probe_dp.sv
module phy_probe_dp
  import phy_probe_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter logic [DATA_W-1:0] CAP_MASK = 16'h1808
)(
  input  logic              clk,
  input  logic              rstN,
  input  probeStrobes_t     strb,
  input  logic [ADDR_W-1:0] prefAddr,
  input  logic [DATA_W-1:0] mdioData,
  output logic [ADDR_W-1:0] candAddr,
  output logic              respOk,
  output logic              addrZero,
  output logic              found,
  output logic [ADDR_W-1:0] foundAddr,
  output logic              done
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  logic [DATA_W-1:0] rdData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      candAddr <= '0;
      rdData   <= '0;
    end else begin
      if (strb.loadPref)     candAddr <= prefAddr;
      else if (strb.loadTop) candAddr <= TOP_ADDR;
      else if (strb.decAddr) candAddr <= candAddr - 1'b1;
      if (strb.capture) rdData <= mdioData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      found     <= 1'b0;
      foundAddr <= '0;
      done      <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.clearRes) begin
        found     <= 1'b0;
        foundAddr <= '0;
      end else if (strb.setFound) begin
        found     <= 1'b1;
        foundAddr <= candAddr;
      end
    end
  end

  assign respOk   = (rdData != ALL_ONES) && ((rdData & CAP_MASK) == CAP_MASK);
  assign addrZero = (candAddr == '0);

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: a reported hit is backed by a word that passes the filter
  assert_found_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && found) |-> (rdData != ALL_ONES && (rdData & CAP_MASK) == CAP_MASK));

  // R6: the descending scan never steps below zero
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.decAddr |-> (candAddr != '0));

endmodule

// File: rtl/phy_probe.sv
module phy_probe
  import phy_probe_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int REG_W    = 5,
  parameter int STAT_REG = 1,
  parameter logic [DATA_W-1:0] CAP_MASK = 16'h1808
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              prefEn,
  input  logic [ADDR_W-1:0] prefAddr,
  output logic              mdioReq,
  output logic [ADDR_W-1:0] mdioAddr,
  output logic [REG_W-1:0]  mdioReg,
  input  logic              mdioBusy,
  input  logic [DATA_W-1:0] mdioData,
  output logic              found,
  output logic [ADDR_W-1:0] foundAddr,
  output logic              done
);

  probeStrobes_t strb;
  logic          respOk;
  logic          addrZero;

  phy_probe_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .prefEn   (prefEn),
    .mdioBusy (mdioBusy),
    .respOk   (respOk),
    .addrZero (addrZero),
    .mdioReq  (mdioReq),
    .strb     (strb)
  );

  phy_probe_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CAP_MASK (CAP_MASK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .prefAddr  (prefAddr),
    .mdioData  (mdioData),
    .candAddr  (mdioAddr),
    .respOk    (respOk),
    .addrZero  (addrZero),
    .found     (found),
    .foundAddr (foundAddr),
    .done      (done)
  );

  assign mdioReg = REG_W'(STAT_REG);

  // R11: address held steady across a pending request
  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (mdioReq && $past(mdioReq)) |-> $stable(mdioAddr));

endmodule

// File: tb/phy_probe_bench.sv
`timescale 1ns/1ps
module phy_probe_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic        prefEn;
  logic [4:0]  prefAddr;
  logic        mdioReq;
  logic [4:0]  mdioAddr;
  logic [4:0]  mdioReg;
  logic        mdioBusy;
  logic [15:0] mdioData;
  logic        found;
  logic [4:0]  foundAddr;
  logic        done;

  always #2.5 clk = ~clk;

  phy_probe u_phy_probe (
    .clk(clk), .rstN(rstN), .start(start), .prefEn(prefEn), .prefAddr(prefAddr),
    .mdioReq(mdioReq), .mdioAddr(mdioAddr), .mdioReg(mdioReg),
    .mdioBusy(mdioBusy), .mdioData(mdioData),
    .found(found), .foundAddr(foundAddr), .done(done)
  );

  logic [15:0] phyTab [0:31];
  int logAddr [0:79];
  int logCnt;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit reqWhileBusy;
  bit badReg;

  // Behavioural MDIO engine, driven on the falling edge
  int engState, engDelay, engDur;
  logic [4:0] engAddr;
  always @(negedge clk) begin
    if (!rstN) begin
      engState <= 0; mdioBusy <= 1'b0; mdioData <= 16'h0;
    end else begin
      case (engState)
        0: if (mdioReq) begin
             engDelay <= $urandom_range(0, 3);
             engState <= 1;
           end
        1: if (!mdioReq) engState <= 0;
           else if (engDelay == 0) begin
             mdioBusy <= 1'b1;
             engAddr  <= mdioAddr;
             if (logCnt < 80) logAddr[logCnt] = int'(mdioAddr);
             logCnt = logCnt + 1;
             if (mdioReg != 5'd1) badReg = 1'b1;
             engDur   <= $urandom_range(1, 4);
             engState <= 2;
           end else engDelay <= engDelay - 1;
        2: if (engDur == 0) begin
             mdioBusy <= 1'b0;
             mdioData <= phyTab[engAddr];
             engState <= 3;
           end else engDur <= engDur - 1;
        default: engState <= 0;
      endcase
    end
  end

  // R8: watch for a request rising while the engine is busy
  logic prevReq;
  always @(negedge clk) begin
    if (rstN && mdioReq && !prevReq && mdioBusy) reqWhileBusy = 1'b1;
    prevReq <= mdioReq;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic bit goodWord(logic [15:0] v);
    return (v != 16'hFFFF) && ((v & 16'h1808) == 16'h1808);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] makeWord(int kind);
    logic [15:0] v;
    int b;
    case (kind)
      0: begin
        v = 16'($urandom) | 16'h1808;
        if (v == 16'hFFFF) v = 16'h1808;
      end
      1: v = 16'hFFFF;
      default: begin
        b = $urandom_range(0, 2);
        v = 16'($urandom) | 16'h1808;
        v[(b == 0) ? 3 : (b == 1) ? 11 : 12] = 1'b0;
      end
    endcase
    return v;
  endfunction

  task automatic fillRandom(int validPct);
    for (int a = 0; a < 32; a++) begin
      int r = $urandom_range(0, 99);
      phyTab[a] = makeWord(r < validPct ? 0 : (r[0] ? 1 : 2));
    end
  endtask

  task automatic fillAll(int kind);
    for (int a = 0; a < 32; a++) phyTab[a] = makeWord(kind);
  endtask

  task automatic pulseStart(bit pe, int pa);
    @(negedge clk);
    prefEn = pe; prefAddr = 5'(pa); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    logCnt = 0; reqWhileBusy = 1'b0; badReg = 1'b0;
  endtask

  task automatic runScan(bit pe, int pa, string tag);
    int expSeq [0:40];
    int expN = 0;
    bit expFound = 1'b0;
    int expAddr = 0;
    int n = 0;
    bit seqOk;
    logic [4:0] hold;
    if (pe) begin
      expSeq[expN++] = pa;
      if (goodWord(phyTab[pa])) begin expFound = 1'b1; expAddr = pa; end
    end
    if (!expFound) begin
      for (int a = 31; a >= 0; a--) begin
        expSeq[expN++] = a;
        if (goodWord(phyTab[a])) begin expFound = 1'b1; expAddr = a; break; end
      end
    end
    pulseStart(pe, pa);
    while (!done && n < 3000) begin @(negedge clk); n++; end
    check(done, {tag, " R9 done seen"}, done, 1);
    check(found == expFound, {tag, expFound ? " R6 found" : " R7 not found"}, found, expFound);
    if (expFound)
      check(foundAddr == 5'(expAddr), {tag, pe ? " R4 addr" : " R6 addr"}, foundAddr, expAddr);
    check(logCnt == expN, {tag, expFound ? " R6 read count" : " R7 read count"}, logCnt, expN);
    seqOk = 1'b1;
    for (int i = 0; i < expN && i < logCnt; i++)
      if (logAddr[i] != expSeq[i]) seqOk = 1'b0;
    check(seqOk, {tag, pe ? " R4 order" : " R5 order"}, logCnt > 0 ? logAddr[0] : -1, expSeq[0]);
    check(!reqWhileBusy, {tag, " R8 req idle"}, reqWhileBusy, 0);
    check(!badReg, {tag, " R2 register 1"}, badReg, 0);
    hold = foundAddr;
    @(negedge clk);
    check(!done, {tag, " R9 single pulse"}, done, 0);
    repeat (4) @(negedge clk);
    check(found == expFound && foundAddr == hold, {tag, " R9 result hold"}, foundAddr, hold);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rstN = 1'b0; start = 1'b0; prefEn = 1'b0; prefAddr = 5'd0;
    logCnt = 0; reqWhileBusy = 1'b0; badReg = 1'b0; prevReq = 1'b0;
    for (int a = 0; a < 32; a++) phyTab[a] = 16'hFFFF;
    repeat (4) @(negedge clk);
    check(!found && !done && !mdioReq && foundAddr == 0, "R1 reset state", {found, done, mdioReq}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed corners
    fillAll(1);               runScan(1'b0, 0, "allFFFF");        // R3 R7
    fillAll(2);               runScan(1'b1, 9, "missingBit");     // R3 R7: 33 reads
    fillAll(1); phyTab[0]  = 16'h1808; runScan(1'b0, 0, "onlyZero");  // R6 lower end
    fillAll(2); phyTab[31] = 16'hFFF7 & 16'hFFFF; phyTab[31] = 16'h7FFF; runScan(1'b0, 0, "onlyTop");
    fillAll(1); phyTab[12] = 16'h1808; runScan(1'b1, 12, "prefHit"); // R4 one read
    fillAll(1); phyTab[12] = 16'h1808; phyTab[20] = 16'h79ED;
    runScan(1'b1, 5, "prefMiss");    // R6 rescan from 31
    fillAll(1); phyTab[7] = 16'h1808; phyTab[3] = 16'h1808;
    runScan(1'b0, 7, "prefOff");     // R5 prefAddr ignored, 7 found by scan order
    phyTab[3] = 16'h1808; phyTab[7] = 16'hFFFF;
    runScan(1'b0, 3, "prefOff2");    // R5

    // R10: restart in mid-sequence
    fillAll(1); phyTab[2] = 16'h1808;
    pulseStart(1'b0, 0);
    while (logCnt < 3) @(negedge clk);
    phyTab[30] = 16'h1808;
    runScan(1'b1, 17, "restart R10");

    // random tables
    for (int t = 0; t < 40; t++) begin
      fillRandom((t % 4) * 3);
      runScan(1'($urandom_range(0, 1)), $urandom_range(0, 31), "random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule